// File: doc/BRIEF.md
# Sliced Four-Cycle Signed Multiplier

This unit multiplies two 32-bit signed integers by walking the first operand one byte at a time across four execute cycles. It multiplies each byte by the whole second operand and adds the shifted partial product into a 64-bit running sum. The cycle in which a request is accepted counts as execute stage E1. The unit then stays occupied through E4, so the next multiply can be accepted at the earliest in E5. A request that arrives while the unit is occupied is dropped, and the unit answers it with a one-cycle reject pulse.

Once the sum is complete it travels down a fixed register chain, so every result leaves the unit at a fixed stage. A narrow operation writes the low 32 bits of the product once, in E9. A wide operation writes the low half in E9 and the high half in E10. Each write carries the destination tag captured at issue, plus a flag that says which half is on the bus, so a consumer can steer the halves into a register pair. The requester must keep the source buses valid through E1–E4, because the unit reads them in every one of those cycles.

Top module: `imul_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `iss_rej` and `wr_vld` on the next edge and cancels every operation in flight, so no write from those operations ever appears.
- R2: A request with `iss_vld`=1 while `busy`=0 is accepted, and that cycle is E1. `busy` is 1 in E2, E3 and E4 and 0 in E5, so a new request can be accepted at the earliest in E5.
- R3: A request with `iss_vld`=1 while `busy`=1 is ignored, and `iss_rej` is 1 for exactly the following cycle. The rejected request does not extend `busy`, does not create a write, and does not alter the tag, mode or data of the operation in flight.
- R4: In stage E(k+1), for k=0..3, the unit reads byte k (`src_a[8k+7:8k]`) together with the whole signed `src_b`. Byte 3 is taken as signed and bytes 0 to 2 as unsigned. The product is the sum over k of byte_k·src_b·2^(8k), taken modulo 2^64. When the operands are held stable, this equals the signed product src_a·src_b.
- R5: With `iss_wide`=0 the unit writes once, in E9, with `wr_hi`=0 and `wr_data` equal to product bits 31:0. `wr_vld` is 0 in E10.
- R6: With `iss_wide`=1 the unit writes product bits 31:0 in E9 with `wr_hi`=0, then product bits 63:32 in E10 with `wr_hi`=1.
- R7: Every write carries on `wr_tag` the `iss_tag` value that was present in the issue cycle.
- R8: When requests are accepted every four cycles, results come out in issue order with no two writes in one cycle. The second operation's E9 write comes four cycles after the first operation's E9 write.
- R9: A rejected request that arrives in the same cycle as a result write leaves that write intact, and the reject pulse still appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue request |
| iss_wide | input | 1 | 0: low 32-bit result, 1: full 64-bit result in two writes |
| iss_tag | input | 5 | Destination tag for the results |
| src_a | input | 32 | First operand, read one byte per cycle E1–E4 |
| src_b | input | 32 | Second operand, read whole in each of E1–E4 |
| busy | output | 1 | Unit occupied (E2–E4); issue refused |
| iss_rej | output | 1 | Pulse one cycle after a refused request |
| wr_vld | output | 1 | Result write strobe |
| wr_hi | output | 1 | 0: low half on wr_data, 1: high half |
| wr_tag | output | 5 | Destination tag of this write |
| wr_data | output | 32 | Result half |

## Verification
Two pairs of events can land in the same cycle. In the first pair, the earlier operation is writing its low half in E9 while the next operation is reading its last operand byte. The bench sets this up by issuing a second multiply five cycles after the first. In the second pair, a refused request arrives in the very cycle in which an earlier result is written. The bench arranges this by adding a second multiply that keeps the unit busy at that point, then presents a request exactly in the first operation's E9. In both cases the bench checks that the written data and tag match the older operation's expected product and that the younger operation still finishes correctly. In the second case it also checks that the reject pulse appears one cycle later.

// File: rtl/imul_pkg.sv
package imul_pkg;
   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } imul_mode_e;

   // byte extension bit: only the most significant slice carries the sign
   function automatic logic slice_ext(input logic msb, input logic is_top);
      return is_top & msb;
   endfunction
endpackage

// File: rtl/imul_slice_acc.sv
module imul_slice_acc
   import imul_pkg::*;
#(
   parameter int DW = 32,
   parameter int SL = 8,
   parameter int TW = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            iss_vld,
   input  logic            iss_wide,
   input  logic [TW-1:0]   iss_tag,
   input  logic [DW-1:0]   src_a,
   input  logic [DW-1:0]   src_b,
   output logic            busy,
   output logic            iss_rej,
   output logic            done_vld,
   output logic            done_wide,
   output logic [TW-1:0]   done_tag,
   output logic [2*DW-1:0] done_prod
);
   localparam int NS  = DW / SL;
   localparam int PW  = (NS > 1) ? $clog2(NS) : 1;
   localparam int PRW = 2 * DW;

   logic [PW-1:0]  ph;
   logic [PRW-1:0] acc, pp, sum, ax, bx;
   logic [SL-1:0]  sl;
   logic           accept, top, ext;
   imul_mode_e     mode_q;
   logic [TW-1:0]  tag_q;

   assign busy   = (ph != '0);
   assign accept = iss_vld && !busy;
   assign top    = (ph == PW'(NS - 1));
   assign sl     = src_a[ph*SL +: SL];
   assign ext    = slice_ext(sl[SL-1], top);
   assign ax     = {{(PRW-SL){ext}}, sl};
   assign bx     = {{DW{src_b[DW-1]}}, src_b};
   assign pp     = (ax * bx) << (32'(ph) * SL);
   assign sum    = (accept ? '0 : acc) + pp;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= '0;
         acc     <= '0;
         iss_rej <= 1'b0;
         mode_q  <= MODE_NARROW;
         tag_q   <= '0;
      end else begin
         iss_rej <= iss_vld && busy;
         if (accept) begin
            ph     <= PW'(1);
            acc    <= sum;
            mode_q <= imul_mode_e'(iss_wide);
            tag_q  <= iss_tag;
         end else if (busy) begin
            acc <= sum;
            ph  <= top ? '0 : ph + PW'(1);
         end
      end
   end

   assign done_vld  = busy && top;
   assign done_wide = (mode_q == MODE_WIDE);
   assign done_tag  = tag_q;
   assign done_prod = sum;

   p_issue_busy_r2: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && !busy) |=> busy);
   p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3)));
   p_rej_keeps_tag_r3: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && busy) |=> ($stable(tag_q) && $stable(mode_q)));
   p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
      done_vld |=> !done_vld);
endmodule

// File: rtl/imul_delay_line.sv
module imul_delay_line #(
   parameter int DEPTH = 5,
   parameter int PRW   = 64,
   parameter int TW    = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_vld,
   input  logic           in_wide,
   input  logic [TW-1:0]  in_tag,
   input  logic [PRW-1:0] in_prod,
   output logic           out_vld,
   output logic           out_wide,
   output logic [TW-1:0]  out_tag,
   output logic [PRW-1:0] out_prod
);
   logic           v [DEPTH+1];
   logic           w [DEPTH+1];
   logic [TW-1:0]  t [DEPTH+1];
   logic [PRW-1:0] p [DEPTH+1];

   assign v[0] = in_vld;
   assign w[0] = in_wide;
   assign t[0] = in_tag;
   assign p[0] = in_prod;

   for (genvar j = 1; j <= DEPTH; j++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            v[j] <= 1'b0;
            w[j] <= 1'b0;
            t[j] <= '0;
            p[j] <= '0;
         end else begin
            v[j] <= v[j-1];
            w[j] <= w[j-1];
            t[j] <= t[j-1];
            p[j] <= p[j-1];
         end
      end
   end

   assign out_vld  = v[DEPTH];
   assign out_wide = w[DEPTH];
   assign out_tag  = t[DEPTH];
   assign out_prod = p[DEPTH];

   p_chain_move_r8: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> v[1]);
endmodule

// File: rtl/imul_seq.sv
module imul_seq
   import imul_pkg::*;
#(
   parameter int DW       = 32,
   parameter int SL       = 8,
   parameter int TW       = 5,
   parameter int WB_STAGE = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          iss_vld,
   input  logic          iss_wide,
   input  logic [TW-1:0] iss_tag,
   input  logic [DW-1:0] src_a,
   input  logic [DW-1:0] src_b,
   output logic          busy,
   output logic          iss_rej,
   output logic          wr_vld,
   output logic          wr_hi,
   output logic [TW-1:0] wr_tag,
   output logic [DW-1:0] wr_data
);
   localparam int NS    = DW / SL;
   localparam int PRW   = 2 * DW;
   localparam int DEPTH = WB_STAGE - NS;

   if (DW % SL != 0) begin : g_bad_slice
      $error("DW must be a multiple of SL");
   end
   if (NS < 2) begin : g_bad_count
      $error("at least two slices required");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("WB_STAGE must exceed the slice count");
   end

   logic           a_vld, a_wide, lo_vld, lo_wide;
   logic [TW-1:0]  a_tag, lo_tag;
   logic [PRW-1:0] a_prod, lo_prod;
   logic           hi_vld;
   logic [TW-1:0]  hi_tag;
   logic [DW-1:0]  hi_data;

   imul_slice_acc #(.DW(DW), .SL(SL), .TW(TW)) u_acc (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_wide(iss_wide),
      .iss_tag(iss_tag), .src_a(src_a), .src_b(src_b), .busy(busy),
      .iss_rej(iss_rej), .done_vld(a_vld), .done_wide(a_wide),
      .done_tag(a_tag), .done_prod(a_prod)
   );

   imul_delay_line #(.DEPTH(DEPTH), .PRW(PRW), .TW(TW)) u_dly (
      .clk(clk), .rst(rst), .in_vld(a_vld), .in_wide(a_wide),
      .in_tag(a_tag), .in_prod(a_prod), .out_vld(lo_vld),
      .out_wide(lo_wide), .out_tag(lo_tag), .out_prod(lo_prod)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_vld  <= 1'b0;
         hi_tag  <= '0;
         hi_data <= '0;
      end else begin
         hi_vld  <= lo_vld && lo_wide;
         hi_tag  <= lo_tag;
         hi_data <= lo_prod[PRW-1:DW];
      end
   end

   assign wr_vld  = lo_vld | hi_vld;
   assign wr_hi   = hi_vld;
   assign wr_tag  = hi_vld ? hi_tag : lo_tag;
   assign wr_data = hi_vld ? hi_data : lo_prod[DW-1:0];

   p_no_clash_r8: assert property (@(posedge clk) disable iff (rst)
      !(lo_vld && hi_vld));
   p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (rst)
      wr_hi |-> $past(wr_vld && !wr_hi));
   p_tag_pair_r7: assert property (@(posedge clk) disable iff (rst)
      wr_hi |-> (wr_tag == $past(wr_tag)));
endmodule

// File: tb/sim_imul_seq.sv
module sim_imul_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        iss_vld = 1'b0, iss_wide = 1'b0;
   logic [4:0]  iss_tag = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic        busy, iss_rej, wr_vld, wr_hi;
   logic [4:0]  wr_tag;
   logic [31:0] wr_data;
   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   imul_seq u0 (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_wide(iss_wide),
      .iss_tag(iss_tag), .src_a(src_a), .src_b(src_b), .busy(busy),
      .iss_rej(iss_rej), .wr_vld(wr_vld), .wr_hi(wr_hi),
      .wr_tag(wr_tag), .wr_data(wr_data)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b);
      logic signed [63:0] x, y;
      x = $signed(a);
      y = $signed(b);
      return x * y;
   endfunction

   // R4 sliced model: byte k of a_k times b_k, shifted 8k
   function automatic logic [63:0] slice_sum(input logic [31:0] a [4], input logic [31:0] b [4]);
      logic [63:0] s = '0;
      for (int k = 0; k < 4; k++) begin
         logic signed [63:0] bx, ax;
         logic [7:0] by;
         by = a[k][8*k +: 8];
         ax = (k == 3) ? 64'($signed(by)) : {56'd0, by};
         bx = $signed(b[k]);
         s = s + ((ax * bx) << (8 * k));
      end
      return s;
   endfunction

   task automatic issue(input logic w, input logic [4:0] tg, input logic [31:0] a, input logic [31:0] b);
      iss_vld = 1'b1; iss_wide = w; iss_tag = tg; src_a = a; src_b = b;
   endtask

   task automatic t_reset();
      chk("R1 busy after reset", 64'(busy), 64'd0);
      chk("R1 wr_vld after reset", 64'(wr_vld), 64'd0);
      chk("R1 iss_rej after reset", 64'(iss_rej), 64'd0);
   endtask

   task automatic t_op(input logic w, input logic [4:0] tg, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] e = sprod(a, b);
      issue(w, tg, a, b);
      chk("R2 busy in E1", 64'(busy), 64'd0);
      for (int i = 0; i < 3; i++) begin
         step();
         iss_vld = 1'b0;
         chk("R2 busy in E2-E4", 64'(busy), 64'd1);
      end
      step();
      chk("R2 busy clear in E5", 64'(busy), 64'd0);
      repeat (4) step();
      chk("R5 low write strobe E9", 64'(wr_vld), 64'd1);
      chk("R5 low half flag", 64'(wr_hi), 64'd0);
      chk("R7 tag on low write", 64'(wr_tag), 64'(tg));
      chk("R4 low product", 64'(wr_data), {32'd0, e[31:0]});
      step();
      if (w) begin
         chk("R6 high write E10", {62'd0, wr_vld, wr_hi}, 64'd3);
         chk("R7 tag on high write", 64'(wr_tag), 64'(tg));
         chk("R6 high product", 64'(wr_data), {32'd0, e[63:32]});
      end else begin
         chk("R5 no E10 write", 64'(wr_vld), 64'd0);
      end
      step();
   endtask

   task automatic t_slices();
      logic [31:0] a [4];
      logic [31:0] b [4];
      logic [63:0] e;
      a = '{32'h1234_56F1, 32'hAB00_7F22, 32'h0099_1133, 32'h8000_0044};
      b = '{32'hFFFF_FFFD, 32'h0000_0100, 32'h7FFF_0001, 32'hC000_0000};
      e = slice_sum(a, b);
      issue(1'b1, 5'd21, a[0], b[0]);
      for (int k = 1; k < 4; k++) begin
         step();
         iss_vld = 1'b0; src_a = a[k]; src_b = b[k];
      end
      repeat (5) step();
      chk("R4 slice timing low", {31'd0, wr_vld, wr_data}, {31'd1, e[31:0]});
      step();
      chk("R4 slice timing high", {31'd0, wr_hi, wr_data}, {31'd1, e[63:32]});
      step();
   endtask

   task automatic t_reject();
      logic [63:0] e = sprod(32'd1000, 32'hFFFF_FF9C);
      issue(1'b0, 5'd3, 32'd1000, 32'hFFFF_FF9C);
      step();
      iss_vld = 1'b1; iss_wide = 1'b1; iss_tag = 5'd9;
      step();
      iss_vld = 1'b0;
      chk("R3 reject pulse", 64'(iss_rej), 64'd1);
      step();
      chk("R3 reject one cycle", 64'(iss_rej), 64'd0);
      step();
      chk("R3 busy not extended", 64'(busy), 64'd0);
      repeat (4) step();
      chk("R3 in-flight write intact", {27'd0, wr_vld, wr_tag, wr_data},
          {27'd0, 1'b1, 5'd3, e[31:0]});
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R3 no write from rejected", 64'(wr_vld), 64'd0);
      end
   endtask

   task automatic t_b2b();
      logic [63:0] ea = sprod(32'h8000_0000, 32'h8000_0000);
      logic [63:0] eb = sprod(32'h7FFF_FFFF, 32'h0000_0003);
      issue(1'b1, 5'd10, 32'h8000_0000, 32'h8000_0000);
      step(); iss_vld = 1'b0;
      repeat (3) step();
      issue(1'b0, 5'd11, 32'h7FFF_FFFF, 32'h0000_0003);
      step(); iss_vld = 1'b0;
      repeat (3) step();
      chk("R8 first low at E9", {26'd0, wr_vld, wr_hi, wr_tag, wr_data},
          {26'd0, 1'b1, 1'b0, 5'd10, ea[31:0]});
      step();
      chk("R8 first high at E10", {26'd0, wr_vld, wr_hi, wr_tag, wr_data},
          {26'd0, 1'b1, 1'b1, 5'd10, ea[63:32]});
      repeat (2) begin
         step();
         chk("R8 gap between results", 64'(wr_vld), 64'd0);
      end
      step();
      chk("R8 second low four cycles later", {26'd0, wr_vld, wr_hi, wr_tag, wr_data},
          {26'd0, 1'b1, 1'b0, 5'd11, eb[31:0]});
      step();
      chk("R8 second narrow single write", 64'(wr_vld), 64'd0);
   endtask

   task automatic t_rej_on_write();
      logic [63:0] ea = sprod(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      logic [63:0] eb = sprod(32'd77, 32'd1234567);
      issue(1'b0, 5'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      step(); iss_vld = 1'b0;
      repeat (4) step();
      issue(1'b0, 5'd13, 32'd77, 32'd1234567);
      step(); iss_vld = 1'b0;
      repeat (2) step();
      iss_vld = 1'b1; iss_tag = 5'd30;
      chk("R9 write during refused request", {27'd0, wr_vld, wr_tag, wr_data},
          {27'd0, 1'b1, 5'd12, ea[31:0]});
      step();
      iss_vld = 1'b0;
      chk("R9 reject pulse after write cycle", 64'(iss_rej), 64'd1);
      repeat (4) step();
      chk("R9 younger op completes", {27'd0, wr_vld, wr_tag, wr_data},
          {27'd0, 1'b1, 5'd13, eb[31:0]});
      step();
   endtask

   task automatic t_flush();
      issue(1'b1, 5'd7, 32'h0102_0304, 32'h0506_0708);
      step(); iss_vld = 1'b0;
      repeat (5) step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      chk("R1 busy clear after mid-flight reset", 64'(busy), 64'd0);
      for (int i = 0; i < 5; i++) begin
         chk("R1 flushed result never written", 64'(wr_vld), 64'd0);
         step();
      end
   endtask

   initial begin
      repeat (3) step();
      rst = 1'b0;
      t_reset();
      t_op(1'b0, 5'd1, 32'd6, 32'd7);
      t_op(1'b1, 5'd2, 32'hFFFF_FFF9, 32'h0001_0003);
      t_op(1'b1, 5'd31, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      t_slices();
      t_reject();
      t_b2b();
      t_rej_on_write();
      t_flush();
      t_op(1'b0, 5'd4, 32'hDEAD_BEEF, 32'h0000_0010);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule